// File: doc/BRIEF.md
# Boot-Time Processor Clock Ramp Sequencer

After reset this block brings a processor clock up from the reference oscillator to its final rate, with no software involved. It first polls a status word owned by a peer subsystem until that word reads exactly one. It then raises the core supply level and waits for the supply to settle. Next it reads two registers: the clock-select register, whose bit 0 gives the step parity, and the PLL multiplier register, which decides between two step tables. Finally it walks a six-entry step table, using every other entry. Each step writes a clock-control word and then a select word, and waits a settling time after the select word.

The sequencer is a bus master with two ports. The read port carries a request, an address, an acknowledge and the returned data. The write port is a valid/ready handshake. On both ports a transfer completes on a rising edge where the request and the acknowledge (or valid and ready) are both high. The settling time is `SETTLE_CYCLES` clock cycles, set to one millisecond of the system clock. When the last settling time ends, `done` rises and stays high until the next reset.

Top module: `clk_ramp_seq`

## Requirements
- R1: After reset the only bus traffic is repeated reads of `STAT_ADDR`. Any value other than exactly 32'h1 (for example 0, 2 or 32'h101) causes another read. No write is issued until a read returns 32'h1.
- R2: The first write goes to `VOLT_ADDR` with data 32'h0000_00B8. In this word bit 7 is the enable and the level 7 sits in bits 6:3. The write is issued in the cycle after the accepting edge of the read that returned 1.
- R3: After the voltage write is accepted, and after every select write is accepted, the next bus request (or `done`) appears exactly `SETTLE_CYCLES` cycles after the accepting edge.
- R4: After the voltage settle, the block reads `SEL_ADDR` and then `MULT_ADDR`, each exactly once. Bit 0 of the select read is the start index s. The block then runs steps s, s+2 and s+4, giving entries 0,2,4 or 1,3,5, so there are always three steps.
- R5: The control word for entry i has 100 in bits 31:16 and zeros in bits 15 and 7. It has a source in bits 14:12 with a divider in 11:8, and a source in 6:4 with a divider in 3:0. The divider code 3 means divide-by-4 and 1 means divide-by-2. The entries are: 0: low source 1, low divider 3. 1: high source 1, high divider 3. 2: high source 1, high divider 1. 3: high source 1, low divider 1. 4: low source 2. 5: high source 2.
- R6: If bits 5:0 of the multiplier read equal 41, entries 4 and 5 carry divider 0. Otherwise they carry divider 1. Bits above bit 5 are ignored.
- R7: Each step writes the control word to `CTRL_ADDR` and then the select word to `SEL_ADDR`. The select word is 3 in bits 2:1, with the slot bit 0 set to 1 for entries 0, 3 and 4 and to 0 for entries 1, 2 and 5. This gives 7 or 6.
- R8: While a request waits for its acknowledge or ready, the address and data stay stable and the request stays high. A read and a write are never requested in the same cycle.
- R9: `done` rises after the final settling time. It stays high until reset, and after it rises no further requests are made.
- R10: While reset is held, `rd_req`, `wr_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read acknowledge; rd_data valid with it |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accept |
| done | output | 1 | Ramp complete, sticky until reset |

## Verification
The bench sweeps both parities of the select bit across four multiplier values. Two of these values carry 41 in bits 5:0 with different upper bits, and two do not. Each combination runs with and without junk status words and with zero and two-cycle bus stalls. A design that tested the status word for nonzero or for bit 0 would write the supply after seeing 32'h101. A design that decoded more than six multiplier bits would pick the normal table for 32'hE9. A design that started at entry 0, or stepped by one, would produce the wrong number or order of writes. The bench measures every settle gap and the `done` rise against the accepting edge, so a timer that is off by one cycle, or a data change during a stall, shows up.

// File: rtl/ramp_seq_pkg.sv
package ramp_seq_pkg;

    localparam int WORD_W     = 32;
    localparam int STEP_COUNT = 6;
    localparam int STEP_IDX_W = 3;
    localparam int ROM_DEPTH  = 1 << STEP_IDX_W;

    localparam logic [3:0] DIV_BY4 = 4'd3;
    localparam logic [3:0] DIV_BY2 = 4'd1;
    localparam logic [3:0] DIV_NONE = 4'd0;

    typedef enum logic [3:0] {
        ST_POLL,
        ST_VOLT,
        ST_VWAIT,
        ST_RDSEL,
        ST_RDMULT,
        ST_CTRL,
        ST_SELW,
        ST_SWAIT,
        ST_DONE
    } ramp_state_e;

    function automatic logic [WORD_W-1:0] pack_ctrl(
        input logic [15:0] wait_cnt,
        input logic [2:0]  src_hi,
        input logic [3:0]  div_hi,
        input logic [2:0]  src_lo,
        input logic [3:0]  div_lo
    );
        return {wait_cnt, 1'b0, src_hi, div_hi, 1'b0, src_lo, div_lo};
    endfunction

endpackage

// File: rtl/ramp_step_table.sv
module ramp_step_table
    import ramp_seq_pkg::*;
#(
    parameter int WAIT_CNT = 100,
    parameter int SRC_BASE = 1,
    parameter int SRC_FAST = 2
) (
    input  logic [STEP_IDX_W-1:0] idx,
    input  logic                  fast,
    output logic [WORD_W-1:0]     ctrl_word,
    output logic [WORD_W-1:0]     sel_word
);

    localparam logic [15:0] WCNT  = 16'(WAIT_CNT);
    localparam logic [2:0]  SBASE = 3'(SRC_BASE);
    localparam logic [2:0]  SFAST = 3'(SRC_FAST);
    localparam logic [STEP_COUNT-1:0] SLOT_MAP = 6'b011001;

    function automatic logic [WORD_W-1:0] step_ctrl(input int e, input logic f);
        logic [3:0] top_div;
        top_div = f ? DIV_NONE : DIV_BY2;
        case (e)
            0:       return pack_ctrl(WCNT, 3'd0,  DIV_NONE, SBASE, DIV_BY4);
            1:       return pack_ctrl(WCNT, SBASE, DIV_BY4,  3'd0,  DIV_NONE);
            2:       return pack_ctrl(WCNT, SBASE, DIV_BY2,  3'd0,  DIV_NONE);
            3:       return pack_ctrl(WCNT, SBASE, DIV_NONE, 3'd0,  DIV_BY2);
            4:       return pack_ctrl(WCNT, 3'd0,  DIV_NONE, SFAST, top_div);
            default: return pack_ctrl(WCNT, SFAST, top_div,  3'd0,  DIV_NONE);
        endcase
    endfunction

    logic [WORD_W-1:0] ctrl_rom [ROM_DEPTH];
    logic [WORD_W-1:0] sel_rom  [ROM_DEPTH];

    for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_entry
        if (g < STEP_COUNT) begin : g_live
            assign ctrl_rom[g] = step_ctrl(g, fast);
            assign sel_rom[g]  = {29'd0, DIV_BY4[1:0], SLOT_MAP[g]};
        end else begin : g_pad
            assign ctrl_rom[g] = '0;
            assign sel_rom[g]  = '0;
        end
    end

    assign ctrl_word = ctrl_rom[idx];
    assign sel_word  = sel_rom[idx];

endmodule

// File: rtl/ramp_settle_timer.sv
module ramp_settle_timer #(
    parameter int CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = (cnt_q == CW'(1));

    // R3
    timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt_q == '0));

    // R3
    timer_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/clk_ramp_seq.sv
module clk_ramp_seq
    import ramp_seq_pkg::*;
#(
    parameter int              ADDR_W        = 16,
    parameter int              SETTLE_CYCLES = 100000,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 16'h0040,
    parameter logic [ADDR_W-1:0] VOLT_ADDR   = 16'h0010,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'h0000,
    parameter logic [ADDR_W-1:0] SEL_ADDR    = 16'h0004,
    parameter logic [ADDR_W-1:0] MULT_ADDR   = 16'h0020,
    parameter int              VOLT_LEVEL    = 7,
    parameter int              FAST_MULT     = 41,
    parameter int              WAIT_CNT      = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              done
);

    localparam logic [WORD_W-1:0]     VOLT_WORD  = WORD_W'(32'h80 | (VOLT_LEVEL << 3));
    localparam logic [5:0]            FAST_CODE  = 6'(FAST_MULT);
    localparam logic [STEP_IDX_W-1:0] STEP_LIMIT = STEP_IDX_W'(STEP_COUNT);

    typedef struct packed {
        ramp_state_e           st;
        logic [STEP_IDX_W-1:0] idx;
        logic                  fast;
        logic                  wr_valid;
        logic [ADDR_W-1:0]     wr_addr;
        logic [WORD_W-1:0]     wr_data;
        logic                  rd_req;
        logic [ADDR_W-1:0]     rd_addr;
        logic                  done;
    } seq_regs_t;

    seq_regs_t         seq_d, seq_q;
    logic              tmr_start;
    logic              tmr_expire;
    logic [WORD_W-1:0] tbl_ctrl;
    logic [WORD_W-1:0] tbl_sel;

    ramp_step_table #(
        .WAIT_CNT (WAIT_CNT)
    ) u_table (
        .idx       (seq_q.idx),
        .fast      (seq_q.fast),
        .ctrl_word (tbl_ctrl),
        .sel_word  (tbl_sel)
    );

    ramp_settle_timer #(
        .CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .expire (tmr_expire)
    );

    always_comb begin
        seq_d     = seq_q;
        tmr_start = 1'b0;
        unique case (seq_q.st)
            ST_POLL: begin
                if (!seq_q.rd_req) begin
                    seq_d.rd_req  = 1'b1;
                    seq_d.rd_addr = STAT_ADDR;
                end else if (rd_ack && rd_data == WORD_W'(1)) begin
                    seq_d.rd_req   = 1'b0;
                    seq_d.wr_valid = 1'b1;
                    seq_d.wr_addr  = VOLT_ADDR;
                    seq_d.wr_data  = VOLT_WORD;
                    seq_d.st       = ST_VOLT;
                end
            end
            ST_VOLT: begin
                if (wr_ready) begin
                    seq_d.wr_valid = 1'b0;
                    tmr_start      = 1'b1;
                    seq_d.st       = ST_VWAIT;
                end
            end
            ST_VWAIT: begin
                if (tmr_expire) begin
                    seq_d.rd_req  = 1'b1;
                    seq_d.rd_addr = SEL_ADDR;
                    seq_d.st      = ST_RDSEL;
                end
            end
            ST_RDSEL: begin
                if (rd_ack) begin
                    seq_d.idx     = {{(STEP_IDX_W-1){1'b0}}, rd_data[0]};
                    seq_d.rd_addr = MULT_ADDR;
                    seq_d.st      = ST_RDMULT;
                end
            end
            ST_RDMULT: begin
                if (rd_ack) begin
                    seq_d.fast   = (rd_data[5:0] == FAST_CODE);
                    seq_d.rd_req = 1'b0;
                    seq_d.st     = ST_CTRL;
                end
            end
            ST_CTRL: begin
                if (!seq_q.wr_valid) begin
                    seq_d.wr_valid = 1'b1;
                    seq_d.wr_addr  = CTRL_ADDR;
                    seq_d.wr_data  = tbl_ctrl;
                end else if (wr_ready) begin
                    seq_d.wr_addr = SEL_ADDR;
                    seq_d.wr_data = tbl_sel;
                    seq_d.st      = ST_SELW;
                end
            end
            ST_SELW: begin
                if (wr_ready) begin
                    seq_d.wr_valid = 1'b0;
                    tmr_start      = 1'b1;
                    seq_d.idx      = seq_q.idx + STEP_IDX_W'(2);
                    seq_d.st       = ST_SWAIT;
                end
            end
            ST_SWAIT: begin
                if (tmr_expire) begin
                    if (seq_q.idx >= STEP_LIMIT) begin
                        seq_d.done = 1'b1;
                        seq_d.st   = ST_DONE;
                    end else begin
                        seq_d.wr_valid = 1'b1;
                        seq_d.wr_addr  = CTRL_ADDR;
                        seq_d.wr_data  = tbl_ctrl;
                        seq_d.st       = ST_CTRL;
                    end
                end
            end
            ST_DONE: begin
                seq_d.done = 1'b1;
            end
            default: begin
                seq_d = seq_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_POLL, idx: '0, fast: 1'b0, wr_valid: 1'b0,
                       wr_addr: '0, wr_data: '0, rd_req: 1'b0,
                       rd_addr: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_req   = seq_q.rd_req;
    assign rd_addr  = seq_q.rd_addr;
    assign wr_valid = seq_q.wr_valid;
    assign wr_addr  = seq_q.wr_addr;
    assign wr_data  = seq_q.wr_data;
    assign done     = seq_q.done;

    // R1
    bad_status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_addr == STAT_ADDR && rd_data != WORD_W'(1))
        |=> (!wr_valid && rd_req && rd_addr == STAT_ADDR));

    // R2
    volt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_addr == STAT_ADDR && rd_data == WORD_W'(1))
        |=> (wr_valid && wr_addr == VOLT_ADDR && wr_data == VOLT_WORD));

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_CTRL || seq_q.st == ST_SELW) |-> (seq_q.idx < STEP_LIMIT));

    // R7
    ctrl_then_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_addr == CTRL_ADDR)
        |=> (wr_valid && wr_addr == SEL_ADDR));

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready)
        |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R8
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_req));

    // R3
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_VWAIT || seq_q.st == ST_SWAIT) |-> (!wr_valid && !rd_req));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_valid && !rd_req));

endmodule

// File: tb/sim_clk_ramp_seq.sv
module sim_clk_ramp_seq;

    localparam int AW     = 16;
    localparam int SETTLE = 12;
    localparam logic [AW-1:0] A_STAT = 16'h0040;
    localparam logic [AW-1:0] A_VOLT = 16'h0010;
    localparam logic [AW-1:0] A_CTRL = 16'h0000;
    localparam logic [AW-1:0] A_SEL  = 16'h0004;
    localparam logic [AW-1:0] A_MULT = 16'h0020;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_ack = 1'b0;
    logic [31:0]   rd_data = '0;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          wr_ready = 1'b0;
    logic          done;

    clk_ramp_seq #(
        .ADDR_W        (AW),
        .SETTLE_CYCLES (SETTLE),
        .STAT_ADDR     (A_STAT),
        .VOLT_ADDR     (A_VOLT),
        .CTRL_ADDR     (A_CTRL),
        .SEL_ADDR      (A_SEL),
        .MULT_ADDR     (A_MULT)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_ready (wr_ready),
        .done     (done)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // scenario
    bit          cfg_sel;
    logic [31:0] cfg_mult;
    int          cfg_polls;
    int          cfg_lat;

    // observed bus events
    int          ev_n;
    bit          ev_wr    [32];
    logic [AW-1:0] ev_addr [32];
    logic [31:0] ev_data  [32];
    int          ev_start [32];
    int          ev_hs    [32];
    int          stat_reads;
    bit          w_pend, r_pend;
    int          w_start, r_start, w_cnt, r_cnt;
    bit          done_seen;
    int          done_cyc;
    bit          mon_on = 0;

    function automatic logic [31:0] junk_status(input int n);
        case (n)
            0:       return 32'h0000_0000;
            1:       return 32'h0000_0101;
            default: return 32'h0000_0002;
        endcase
    endfunction

    function automatic logic [31:0] read_value(input logic [AW-1:0] a, input int sn);
        if (a == A_STAT) return (sn < cfg_polls) ? junk_status(sn) : 32'h1;
        if (a == A_SEL)  return 32'hA5A5_A5A4 | {31'd0, cfg_sel};
        if (a == A_MULT) return cfg_mult;
        return 32'hDEAD_0000;
    endfunction

    task automatic log_event(input bit is_wr, input logic [AW-1:0] a,
                             input logic [31:0] d, input int st);
        if (ev_n < 32) begin
            ev_wr[ev_n]    = is_wr;
            ev_addr[ev_n]  = a;
            ev_data[ev_n]  = d;
            ev_start[ev_n] = st;
            ev_hs[ev_n]    = cyc + 1;
        end
        ev_n = ev_n + 1;
    endtask

    // responder and monitor, active away from the rising edge
    always @(negedge clk) begin
        bit rdy, ack;
        if (mon_on && rst_n) begin
            rdy = 1'b0;
            if (wr_valid) begin
                if (!w_pend) begin w_pend = 1; w_start = cyc; w_cnt = 0; end
                rdy = (w_cnt >= cfg_lat);
                if (rdy) begin
                    log_event(1'b1, wr_addr, wr_data, w_start);
                    w_pend = 0;
                end else begin
                    w_cnt = w_cnt + 1;
                end
            end
            wr_ready = rdy;

            ack = 1'b0;
            if (rd_req) begin
                if (!r_pend) begin r_pend = 1; r_start = cyc; r_cnt = 0; end
                ack = (r_cnt >= cfg_lat);
                rd_data = read_value(rd_addr, stat_reads);
                if (ack) begin
                    log_event(1'b0, rd_addr, rd_data, r_start);
                    if (rd_addr == A_STAT) stat_reads = stat_reads + 1;
                    r_pend = 0;
                end else begin
                    r_cnt = r_cnt + 1;
                end
            end
            rd_ack = ack;

            if (done && !done_seen) begin
                done_seen = 1;
                done_cyc  = cyc;
            end
        end else begin
            wr_ready = 1'b0;
            rd_ack   = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // expected control word from the field layout of R5/R6
    function automatic logic [31:0] exp_ctrl(input int i, input bit fast);
        int sh, dh, sl, dl;
        sh = 0; dh = 0; sl = 0; dl = 0;
        case (i)
            0: begin sl = 1; dl = 3; end
            1: begin sh = 1; dh = 3; end
            2: begin sh = 1; dh = 1; end
            3: begin sh = 1; dl = 1; end
            4: begin sl = 2; dl = fast ? 0 : 1; end
            default: begin sh = 2; dh = fast ? 0 : 1; end
        endcase
        return 32'((100 << 16) + (sh << 12) + (dh << 8) + (sl << 4) + dl);
    endfunction

    // expected select word from R7
    function automatic logic [31:0] exp_sel(input int i);
        int slot;
        slot = (i == 0 || i == 3 || i == 4) ? 1 : 0;
        return 32'((3 << 1) + slot);
    endfunction

    task automatic run_case(input bit s, input logic [31:0] m, input int polls, input int lat);
        bit          x_wr    [32];
        logic [AW-1:0] x_addr [32];
        logic [31:0] x_data  [32];
        bit          x_timed [32];
        int          xn;
        bit          fast;
        string       tag;
        int          waited;

        cfg_sel = s; cfg_mult = m; cfg_polls = polls; cfg_lat = lat;
        tag = $sformatf("sel=%0d mult=%h polls=%0d lat=%0d", s, m, polls, lat);

        @(negedge clk);
        rst_n = 1'b0;
        mon_on = 0;
        ev_n = 0; stat_reads = 0; w_pend = 0; r_pend = 0;
        done_seen = 0; done_cyc = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!wr_valid && !rd_req && !done, "R10", {"reset outputs ", tag},
            {29'd0, wr_valid, rd_req, done}, 32'd0);
        mon_on = 1;
        rst_n = 1'b1;

        waited = 0;
        while (!done_seen && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_seen, "R9", {"done raised ", tag}, {31'd0, done_seen}, 32'd1);
        repeat (25) @(negedge clk);

        // build expected sequence
        fast = (m[5:0] == 6'd41);
        xn = 0;
        for (int k = 0; k <= polls; k++) begin
            x_wr[xn] = 0; x_addr[xn] = A_STAT; x_data[xn] = 0; x_timed[xn] = 0; xn++;
        end
        x_wr[xn] = 1; x_addr[xn] = A_VOLT; x_data[xn] = 32'h0000_00B8; x_timed[xn] = 0; xn++;
        x_wr[xn] = 0; x_addr[xn] = A_SEL;  x_data[xn] = 0; x_timed[xn] = 1; xn++;
        x_wr[xn] = 0; x_addr[xn] = A_MULT; x_data[xn] = 0; x_timed[xn] = 0; xn++;
        for (int i = int'(s); i < 6; i += 2) begin
            x_wr[xn] = 1; x_addr[xn] = A_CTRL; x_data[xn] = exp_ctrl(i, fast);
            x_timed[xn] = (i != int'(s)); xn++;
            x_wr[xn] = 1; x_addr[xn] = A_SEL;  x_data[xn] = exp_sel(i); x_timed[xn] = 0; xn++;
        end

        // R4/R9: total number of bus transfers, nothing after done
        chk(ev_n == xn, "R9", {"transfer count ", tag}, 32'(ev_n), 32'(xn));
        chk(done === 1'b1, "R9", {"done sticky ", tag}, {31'd0, done}, 32'd1);

        for (int k = 0; k < xn && k < ev_n; k++) begin
            string rq;
            if (k <= polls) rq = "R1";
            else if (x_addr[k] == A_VOLT) rq = "R2";
            else if (!x_wr[k]) rq = "R4";
            else if (x_addr[k] == A_SEL) rq = "R7";
            else rq = (k >= xn - 4) ? "R6" : "R5";
            chk(ev_wr[k] == x_wr[k] && ev_addr[k] == x_addr[k], rq,
                $sformatf("transfer %0d kind/addr %s", k, tag),
                {15'd0, ev_wr[k], ev_addr[k]}, {15'd0, x_wr[k], x_addr[k]});
            if (x_wr[k])
                chk(ev_data[k] == x_data[k], rq,
                    $sformatf("transfer %0d data %s", k, tag), ev_data[k], x_data[k]);
            if (x_timed[k] && k > 0)
                chk(ev_start[k] == ev_hs[k-1] + SETTLE, "R3",
                    $sformatf("settle before transfer %0d %s", k, tag),
                    32'(ev_start[k]), 32'(ev_hs[k-1] + SETTLE));
        end
        if (ev_n == xn && xn > 0)
            chk(done_cyc == ev_hs[xn-1] + SETTLE, "R3",
                {"settle before done ", tag}, 32'(done_cyc), 32'(ev_hs[xn-1] + SETTLE));
        // R8: with stalls, each transfer waited lat cycles after its request
        if (ev_n == xn && xn > 0)
            chk(ev_hs[0] - ev_start[0] == lat + 1, "R8", {"stall honoured ", tag},
                32'(ev_hs[0] - ev_start[0]), 32'(lat + 1));
    endtask

    logic [31:0] mults [4] = '{32'h0000_0029, 32'h0000_0028, 32'h0000_00E9, 32'h0000_003F};

    initial begin
        for (int s = 0; s < 2; s++)
            for (int mi = 0; mi < 4; mi++)
                for (int p = 0; p < 3; p += 2)
                    for (int l = 0; l < 3; l += 2)
                        run_case(s[0], mults[mi], p, l);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule